// File: doc/BRIEF.md
# Tagged Synchronizing Word Memory Controller

This block is a word memory in which every 64-bit word carries four access-state tag bits beside its data: two trap bits, an indirection marker and a full/empty bit. Requesters send loads and stores with a synchronization mode and a protection-domain number. Each access is checked against the word's tags. It then completes, is sent back as a retry, or ends in a trap. In this way producer/consumer threads can hand values to each other through single words, with no lock variables.

Failed synchronized accesses are not queued inside the block. The requester carries its own failure count in the request and gets the incremented count back in a retry response. The block compares that count against a limit register held per protection domain. When the limit is passed, the block answers with a trap whose cause code says the retry budget ran out. Setting a trap bit on a word makes every later load or store to it trap, and the word is left as it was. A word marked indirect completes normally and is flagged in the response. The block does not follow the indirection.

Requests and responses use valid/ready handshakes. The block accepts at most one request per cycle, answers in order, and has exactly one response register.

Top module: `tsm_ctrl`

## Requirements
- R1: After reset, rsp_valid is low, req_ready is high, every word holds zero data with all tag bits clear (empty), and every domain's retry limit equals DEF_LIMIT.
- R2: req_ready equals (not rsp_valid) or rsp_ready. A request accepted at a clock edge yields its response, registered, right after that edge. A stalled response (rsp_valid high, rsp_ready low) holds all its fields. Responses come back in acceptance order.
- R3: req_addr is a byte address. The word index is req_addr[ADDR_W-1:3], and the three low bits have no effect.
- R4: Mode 0 (plain) ignores the full/empty bit. A load returns the data with status OK. A store writes the data and leaves the tag unchanged. Status codes: 0 OK, 1 RETRY, 2 TRAP. Op codes: 0 load, 1 store, 2 tag-write, 3 reserved. Mode codes: 0 plain, 1 read-when-full, 2 take, 3 put.
- R5: A mode-1 load of a full word returns the data, and the word stays full. On an empty word it fails the synchronization test.
- R6: A mode-2 load of a full word returns the data and leaves the word empty. On an empty word it fails the test.
- R7: A mode-3 store to an empty word writes the data and sets the word full. On a full word it fails the test.
- R8: A store in mode 1 or 2, a load in mode 3, and the reserved op all return TRAP with cause 4 (bad mode), and the word is left unchanged.
- R9: A failed test with req_retry below the domain's limit returns RETRY with rsp_retry = req_retry+1. When req_retry is at or above the limit, it returns TRAP with cause 1 (retry exceeded). In both cases the word is unchanged.
- R10: A pulse on lim_we sets the limit of domain lim_dom to lim_val at that edge. A request accepted at the same edge still uses the old limit. Each domain's limit is independent of the others.
- R11: A load or store to a word whose tag bit 3 (trap 0) or tag bit 2 (trap 1) is set returns TRAP with cause 2 or 3, and the word is unchanged. Trap 0 wins when both bits are set. These checks come before the bad-mode and full/empty checks.
- R12: An OK load or store response sets rsp_indirect to the word's tag bit 1 (indirect) as it was before the access.
- R13: Op 2 (tag-write) replaces the word's tag with req_wdata[3:0] = {trap0, trap1, indirect, full} and leaves the data alone. It always returns OK, whatever the mode and the existing tags.
- R14: rsp_data is zero on every response except an OK load. rsp_retry is zero except on RETRY. rsp_cause is 0 except on TRAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 tag-write, 3 reserved |
| req_mode | input | 2 | Synchronization mode |
| req_dom | input | DOM_W | Protection domain of the requester |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, or new tag in bits [3:0] |
| req_retry | input | RETRY_W | Failures this reference has had so far |
| lim_we | input | 1 | Write one domain's retry limit |
| lim_dom | input | DOM_W | Domain whose limit is written |
| lim_val | input | RETRY_W | New retry limit |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_status | output | 2 | 0 OK, 1 RETRY, 2 TRAP |
| rsp_cause | output | 3 | 0 none, 1 retry exceeded, 2 trap 0, 3 trap 1, 4 bad mode |
| rsp_data | output | 64 | Load data |
| rsp_indirect | output | 1 | Word was marked indirect |
| rsp_retry | output | RETRY_W | Incremented failure count on RETRY |

## Verification
A response is due in the first cycle after the edge that accepted its request. A change to a word's data or tag is seen by a request accepted at any later edge. A limit write counts only for requests accepted after its own edge. The bench drives and samples at the falling edge. Just before each rising edge it decides from the settled req_ready whether the request will be taken. It updates a behavioural model of words, tags and limits in acceptance order, and queues the expected response. At every falling edge it compares rsp_valid and the front of that queue with the outputs.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    localparam int DATA_W = 64;
    localparam int TAG_W  = 4;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_SETTAG = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SM_PLAIN    = 2'd0,
        SM_READFULL = 2'd1,
        SM_TAKE     = 2'd2,
        SM_PUT      = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_RETRY = 2'd1,
        ST_TRAP  = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        C_NONE      = 3'd0,
        C_RETRY_EXC = 3'd1,
        C_TRAP0     = 3'd2,
        C_TRAP1     = 3'd3,
        C_BAD_MODE  = 3'd4
    } cause_e;

    typedef struct packed {
        logic trap0;
        logic trap1;
        logic indirect;
        logic full;
    } tag_t;

    typedef struct packed {
        tag_t              tag;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef struct packed {
        status_e           status;
        cause_e            cause;
        logic [DATA_W-1:0] data;
        logic              indirect;
    } rsp_t;

    // Legal op/mode pairs for loads and stores.
    function automatic logic mode_legal(op_e op, mode_e m);
        case (op)
            OP_LOAD:  return (m != SM_PUT);
            OP_STORE: return (m == SM_PLAIN) || (m == SM_PUT);
            default:  return 1'b0;
        endcase
    endfunction

    // Full/empty test for a legal access.
    function automatic logic sync_pass(mode_e m, tag_t t);
        case (m)
            SM_PLAIN:    return 1'b1;
            SM_READFULL: return t.full;
            SM_TAKE:     return t.full;
            default:     return !t.full;
        endcase
    endfunction

endpackage

// File: rtl/tsm_tag_store.sv
module tsm_tag_store
    import tsm_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_word
);

    word_t mem [WORDS];

    assign rd_word = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[wr_idx] <= wr_word;
        end
    end

endmodule

// File: rtl/tsm_limit_regs.sv
module tsm_limit_regs #(
    parameter int DOMAINS   = 16,
    parameter int RETRY_W   = 4,
    parameter int DEF_LIMIT = 3,
    localparam int DOM_W = $clog2(DOMAINS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [DOM_W-1:0]   wdom,
    input  logic [RETRY_W-1:0] wval,
    input  logic [DOM_W-1:0]   rd_dom,
    output logic [RETRY_W-1:0] rd_lim
);

    logic [RETRY_W-1:0] lim_q [DOMAINS];

    for (genvar g = 0; g < DOMAINS; g++) begin : g_dom
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[g] <= RETRY_W'(DEF_LIMIT);
            end else if (we && (wdom == DOM_W'(g))) begin
                lim_q[g] <= wval;
            end
        end
    end

    assign rd_lim = lim_q[rd_dom];

endmodule

// File: rtl/tsm_sync_eval.sv
module tsm_sync_eval
    import tsm_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input  op_e                op,
    input  mode_e              mode,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [RETRY_W-1:0] retry,
    input  logic [RETRY_W-1:0] limit,
    input  word_t              cur,
    output logic               we,
    output word_t              nxt,
    output rsp_t               rsp,
    output logic [RETRY_W-1:0] retry_out
);

    always_comb begin
        we           = 1'b0;
        nxt          = cur;
        rsp.status   = ST_OK;
        rsp.cause    = C_NONE;
        rsp.data     = '0;
        rsp.indirect = 1'b0;
        retry_out    = '0;

        if (op == OP_SETTAG) begin
            we      = 1'b1;
            nxt.tag = tag_t'(wdata[TAG_W-1:0]);
        end else if (cur.tag.trap0) begin
            rsp.status = ST_TRAP;
            rsp.cause  = C_TRAP0;
        end else if (cur.tag.trap1) begin
            rsp.status = ST_TRAP;
            rsp.cause  = C_TRAP1;
        end else if (!mode_legal(op, mode)) begin
            rsp.status = ST_TRAP;
            rsp.cause  = C_BAD_MODE;
        end else if (sync_pass(mode, cur.tag)) begin
            rsp.indirect = cur.tag.indirect;
            if (op == OP_LOAD) begin
                rsp.data = cur.data;
                if (mode == SM_TAKE) begin
                    we           = 1'b1;
                    nxt.tag.full = 1'b0;
                end
            end else begin
                we       = 1'b1;
                nxt.data = wdata;
                if (mode == SM_PUT) begin
                    nxt.tag.full = 1'b1;
                end
            end
        end else if (retry >= limit) begin
            rsp.status = ST_TRAP;
            rsp.cause  = C_RETRY_EXC;
        end else begin
            rsp.status = ST_RETRY;
            retry_out  = retry + 1'b1;
        end
    end

endmodule

// File: rtl/tsm_ctrl.sv
module tsm_ctrl
    import tsm_pkg::*;
#(
    parameter int WORDS     = 64,
    parameter int DOMAINS   = 16,
    parameter int RETRY_W   = 4,
    parameter int DEF_LIMIT = 3,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int ADDR_W = IDX_W + 3,
    localparam int DOM_W  = $clog2(DOMAINS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [1:0]         req_mode,
    input  logic [DOM_W-1:0]   req_dom,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [63:0]        req_wdata,
    input  logic [RETRY_W-1:0] req_retry,
    input  logic               lim_we,
    input  logic [DOM_W-1:0]   lim_dom,
    input  logic [RETRY_W-1:0] lim_val,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [1:0]         rsp_status,
    output logic [2:0]         rsp_cause,
    output logic [63:0]        rsp_data,
    output logic               rsp_indirect,
    output logic [RETRY_W-1:0] rsp_retry
);

    logic               accept;
    logic [IDX_W-1:0]   idx;
    logic [2:0]         byte_lane_unused;
    word_t              cur_word;
    word_t              nxt_word;
    logic               ev_we;
    logic               st_we;
    rsp_t               ev_rsp;
    logic [RETRY_W-1:0] ev_retry;
    logic [RETRY_W-1:0] dom_limit;
    rsp_t               rsp_q;
    logic [RETRY_W-1:0] retry_q;

    assign req_ready        = !rsp_valid || rsp_ready;
    assign accept           = req_valid && req_ready;
    assign idx              = req_addr[ADDR_W-1:3];
    assign byte_lane_unused = req_addr[2:0];
    assign st_we            = accept && ev_we;

    tsm_tag_store #(.WORDS(WORDS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (idx),
        .rd_word (cur_word),
        .we      (st_we),
        .wr_idx  (idx),
        .wr_word (nxt_word)
    );

    tsm_limit_regs #(
        .DOMAINS   (DOMAINS),
        .RETRY_W   (RETRY_W),
        .DEF_LIMIT (DEF_LIMIT)
    ) u_limits (
        .clk    (clk),
        .rst    (rst),
        .we     (lim_we),
        .wdom   (lim_dom),
        .wval   (lim_val),
        .rd_dom (req_dom),
        .rd_lim (dom_limit)
    );

    tsm_sync_eval #(.RETRY_W(RETRY_W)) u_eval (
        .op        (op_e'(req_op)),
        .mode      (mode_e'(req_mode)),
        .wdata     (req_wdata),
        .retry     (req_retry),
        .limit     (dom_limit),
        .cur       (cur_word),
        .we        (ev_we),
        .nxt       (nxt_word),
        .rsp       (ev_rsp),
        .retry_out (ev_retry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
            retry_q   <= '0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_q     <= ev_rsp;
            retry_q   <= ev_retry;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    assign rsp_status   = rsp_q.status;
    assign rsp_cause    = rsp_q.cause;
    assign rsp_data     = rsp_q.data;
    assign rsp_indirect = rsp_q.indirect;
    assign rsp_retry    = retry_q;

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> req_ready);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
            && $stable(rsp_status) && $stable(rsp_cause) && $stable(rsp_retry)));

    // R9
    retry_count_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_RETRY) |-> (rsp_retry != '0 && rsp_cause == C_NONE));

    // R11
    trap_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_TRAP) |-> (rsp_data == '0 && rsp_cause != C_NONE
            && !rsp_indirect));

    // R8
    no_write_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && ev_rsp.status != ST_OK) |-> !st_we);

endmodule

// File: tb/sim_tsm_ctrl.sv
module sim_tsm_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;
    localparam int DOMAINS    = 16;
    localparam int RETRY_W    = 4;
    localparam int DEF_LIMIT  = 3;
    localparam int ADDR_W     = $clog2(WORDS) + 3;
    localparam int DOM_W      = $clog2(DOMAINS);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [1:0]         req_op = '0;
    logic [1:0]         req_mode = '0;
    logic [DOM_W-1:0]   req_dom = '0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [63:0]        req_wdata = '0;
    logic [RETRY_W-1:0] req_retry = '0;
    logic               lim_we = 1'b0;
    logic [DOM_W-1:0]   lim_dom = '0;
    logic [RETRY_W-1:0] lim_val = '0;
    logic               rsp_valid;
    logic               rsp_ready = 1'b1;
    logic [1:0]         rsp_status;
    logic [2:0]         rsp_cause;
    logic [63:0]        rsp_data;
    logic               rsp_indirect;
    logic [RETRY_W-1:0] rsp_retry;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsm_ctrl #(
        .WORDS(WORDS), .DOMAINS(DOMAINS), .RETRY_W(RETRY_W), .DEF_LIMIT(DEF_LIMIT)
    ) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_mode(req_mode), .req_dom(req_dom), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_retry(req_retry),
        .lim_we(lim_we), .lim_dom(lim_dom), .lim_val(lim_val),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_cause(rsp_cause), .rsp_data(rsp_data), .rsp_indirect(rsp_indirect),
        .rsp_retry(rsp_retry)
    );

    // Behavioural model state
    logic [63:0] m_data [WORDS];
    logic [3:0]  m_tag  [WORDS];
    int          m_lim  [DOMAINS];

    int          q_st [$];
    int          q_cs [$];
    logic [63:0] q_d  [$];
    bit          q_in [$];
    int          q_rc [$];
    string       q_tg [$];

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string tag_over = "";

    task automatic check(bit ok, string req, string what, longint unsigned act,
                         longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model of one accepted request: pushes the expected response.
    task automatic model_accept(int op, int mode, int dom, int addr,
                                logic [63:0] wd, int rt);
        int          w = addr / 8;
        logic [3:0]  t = m_tag[w];
        int          st = 0, cs = 0, rc = 0;
        logic [63:0] d = '0;
        bit          ind = 1'b0;
        bit          legal, pass;
        string       tg;
        if (op == 2) begin
            m_tag[w] = wd[3:0];
            tg = "R13";
        end else if (t[3]) begin
            st = 2; cs = 2; tg = "R11";
        end else if (t[2]) begin
            st = 2; cs = 3; tg = "R11";
        end else begin
            legal = (op == 0) ? (mode != 3) : (op == 1) ? (mode == 0 || mode == 3) : 1'b0;
            if (!legal) begin
                st = 2; cs = 4; tg = "R8";
            end else begin
                pass = (mode == 0) ? 1'b1 : (mode == 3) ? !t[0] : t[0];
                if (pass) begin
                    ind = t[1];
                    tg = (mode == 0) ? "R4" : (mode == 1) ? "R5" : (mode == 2) ? "R6" : "R7";
                    if (ind) tg = "R12";
                    if (op == 0) begin
                        d = m_data[w];
                        if (mode == 2) m_tag[w][0] = 1'b0;
                    end else begin
                        m_data[w] = wd;
                        if (mode == 3) m_tag[w][0] = 1'b1;
                    end
                end else if (rt >= m_lim[dom]) begin
                    st = 2; cs = 1; tg = "R9";
                end else begin
                    st = 1; rc = rt + 1; tg = "R9";
                end
            end
        end
        if (tag_over != "") tg = tag_over;
        q_st.push_back(st); q_cs.push_back(cs); q_d.push_back(d);
        q_in.push_back(ind); q_rc.push_back(rc); q_tg.push_back(tg);
    endtask

    // One clock: compare at falling edge, drive, predict, advance.
    task automatic cyc(bit v, int op, int mode, int dom, int addr, logic [63:0] wd,
                       int rt, bit rr, bit lwe = 1'b0, int ldom = 0, int lval = 0);
        bit acc;
        check(rsp_valid == (q_st.size() != 0), "R2", "rsp_valid",
              rsp_valid, q_st.size() != 0);
        if (rsp_valid && q_st.size() != 0) begin
            check(rsp_status == 2'(q_st[0]), q_tg[0], "status", rsp_status, q_st[0]);
            check(rsp_cause == 3'(q_cs[0]), q_tg[0], "cause", rsp_cause, q_cs[0]);
            check(rsp_data == q_d[0], "R14", "data", rsp_data, q_d[0]);
            check(rsp_indirect == q_in[0], "R12", "indirect", rsp_indirect, q_in[0]);
            check(rsp_retry == RETRY_W'(q_rc[0]), "R9", "retry", rsp_retry, q_rc[0]);
        end
        req_valid = v;
        req_op    = 2'(op);
        req_mode  = 2'(mode);
        req_dom   = DOM_W'(dom);
        req_addr  = ADDR_W'(addr);
        req_wdata = wd;
        req_retry = RETRY_W'(rt);
        rsp_ready = rr;
        lim_we    = lwe;
        lim_dom   = DOM_W'(ldom);
        lim_val   = RETRY_W'(lval);
        #1;
        check(req_ready == ((q_st.size() == 0) || rr), "R2", "req_ready",
              req_ready, (q_st.size() == 0) || rr);
        acc = v && req_ready;
        if (rsp_valid && rr && q_st.size() != 0) begin
            void'(q_st.pop_front()); void'(q_cs.pop_front()); void'(q_d.pop_front());
            void'(q_in.pop_front()); void'(q_rc.pop_front()); void'(q_tg.pop_front());
        end
        if (acc) model_accept(op, mode, dom, addr, wd, rt);
        if (lwe) m_lim[ldom] = lval;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, '0, 0, 1);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            m_data[i] = '0;
            m_tag[i]  = '0;
        end
        for (int i = 0; i < DOMAINS; i++) m_lim[i] = DEF_LIMIT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        tag_over = "R1";
        cyc(1, 0, 0, 0, 5*8, '0, 0, 1);            // reset word reads zero, plain
        cyc(1, 0, 1, 0, 6*8, '0, 2, 1);            // empty after reset: retry 3 under limit 3
        cyc(1, 0, 1, 0, 6*8, '0, 3, 1);            // at default limit: trap
        tag_over = "";

        // R4 plain store/load
        cyc(1, 1, 0, 0, 1*8, 64'hA5A5_0000_1234_5678, 0, 1);
        cyc(1, 0, 0, 0, 1*8, '0, 0, 1);
        // R3 low address bits ignored
        tag_over = "R3";
        cyc(1, 0, 0, 0, 1*8 + 7, '0, 0, 1);
        cyc(1, 1, 0, 0, 1*8 + 3, 64'h0000_0000_0000_BEEF, 0, 1);
        cyc(1, 0, 0, 0, 1*8 + 1, '0, 0, 1);
        tag_over = "";

        // R5/R7/R6 sync sequence on word 2
        cyc(1, 0, 1, 0, 2*8, '0, 0, 1);            // R5 empty -> retry
        cyc(1, 1, 3, 0, 2*8, 64'h1111_2222_3333_4444, 0, 1);   // R7 put
        cyc(1, 1, 3, 0, 2*8, 64'h5555, 1, 1);      // R7 full -> retry
        cyc(1, 0, 1, 0, 2*8, '0, 0, 1);            // R5 full, stays
        cyc(1, 0, 1, 0, 2*8, '0, 0, 1);
        cyc(1, 0, 2, 0, 2*8, '0, 0, 1);            // R6 take
        cyc(1, 0, 2, 0, 2*8, '0, 0, 1);            // R6 now empty -> retry
        cyc(1, 0, 2, 0, 2*8, '0, 3, 1);            // R9 exceeded

        // R10 limit writes
        tag_over = "R10";
        cyc(1, 0, 1, 5, 9*8, '0, 0, 1, 1, 5, 0);   // same edge: old limit 3 -> retry
        cyc(1, 0, 1, 5, 9*8, '0, 0, 1);            // limit 0 -> trap
        cyc(1, 0, 1, 6, 9*8, '0, 0, 1);            // other domain unchanged
        cyc(0, 0, 0, 0, 0, '0, 0, 1, 1, 7, 15);
        cyc(1, 0, 1, 7, 9*8, '0, 14, 1);
        cyc(1, 0, 1, 7, 9*8, '0, 15, 1);
        tag_over = "";

        // R8 bad combos, word unchanged
        cyc(1, 1, 1, 0, 1*8, 64'hDEAD, 0, 1);
        cyc(1, 1, 2, 0, 1*8, 64'hDEAD, 0, 1);
        cyc(1, 0, 3, 0, 1*8, '0, 0, 1);
        cyc(1, 3, 0, 0, 1*8, '0, 0, 1);
        cyc(1, 0, 0, 0, 1*8, '0, 0, 1);

        // R11 trap bits, R13 tag writes
        cyc(1, 1, 0, 0, 3*8, 64'hCAFE, 0, 1);
        cyc(1, 2, 3, 0, 3*8, 64'h8, 0, 1);         // trap0
        cyc(1, 1, 0, 0, 3*8, 64'hF00D, 0, 1);
        cyc(1, 0, 2, 0, 3*8, '0, 0, 1);
        cyc(1, 2, 0, 0, 3*8, 64'h4, 0, 1);         // trap1
        cyc(1, 0, 0, 0, 3*8, '0, 0, 1);
        cyc(1, 2, 0, 0, 3*8, 64'hC, 0, 1);         // both: trap0 wins
        cyc(1, 1, 3, 0, 3*8, '0, 0, 1);
        cyc(1, 2, 1, 0, 3*8, 64'h3, 0, 1);         // full+indirect, data kept
        cyc(1, 0, 2, 0, 3*8, '0, 0, 1);            // R12 indirect on OK
        cyc(1, 0, 2, 0, 3*8, '0, 0, 1);            // empty now -> retry

        // R2 stalls with back-pressure
        cyc(1, 0, 0, 0, 1*8, '0, 0, 0);
        cyc(1, 1, 0, 0, 4*8, 64'h77, 0, 0);
        cyc(1, 1, 0, 0, 4*8, 64'h77, 0, 0);
        cyc(1, 0, 0, 0, 4*8, '0, 0, 1);
        cyc(1, 0, 0, 0, 4*8, '0, 0, 1);
        idle();

        // Mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            int op = ($urandom % 10 < 1) ? 2 : int'($urandom % 2);
            logic [63:0] wd;
            if ($urandom % 40 == 0) op = 3;
            wd = {$urandom, $urandom};
            if (op == 2) wd = {60'h0, ($urandom % 8 == 0), ($urandom % 8 == 0), 2'($urandom)};
            cyc(($urandom % 5) != 0, op, int'($urandom % 4), int'($urandom % DOMAINS),
                int'($urandom % 64), wd, int'($urandom % 6), ($urandom % 4) != 0,
                ($urandom % 10) == 0, int'($urandom % DOMAINS), int'($urandom % 5));
        end
        idle();
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule